// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a series of single-element memory requests. A start pulse captures a base address, an addressing mode, an element width, a signed stride and a run-time element count. The sequencer then presents one element request at a time to the memory side over a ready/valid handshake. Each request carries the byte address, the element number and a flag marking the final element.

Three addressing modes share one element counter. In unit-stride mode the address steps by the element size. In strided mode it steps by a signed byte stride. In indexed mode, used for both gather and scatter, each address is the base plus a byte offset. These offsets arrive one per accepted request on a separate index stream. A one-cycle completion pulse follows the last accepted request.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset, `reqValid`, `busy` and `done` are low.
- R2: A `start` pulse seen while `busy` is low captures `baseAddr`, `stride`, `addrMode`, `elemWidth` and `vecLen`, and `busy` rises in the next cycle. Later changes on these inputs do not affect the run in progress. A `start` seen while `busy` is high, including the cycle of the final accepted request, is ignored.
- R3: With `addrMode` = 0 (unit stride), element i is addressed at base + i × size. The size is 1, 2, 4 or 8 bytes for `elemWidth` codes 0, 1, 2 and 3.
- R4: With `addrMode` = 1 (strided), element i is addressed at base + i × stride. The stride is a two's-complement byte offset, and the sum wraps modulo 2^ADDR_W.
- R5: With `addrMode` = 2 or 3 (indexed), element i is addressed at base + the i-th offset on `idxOffset`. A request is valid only while `idxValid` is high. `idxReady` is high only while busy in indexed mode with `reqReady` high, and an offset is consumed when `idxValid` and `idxReady` are both high.
- R6: A request advances to the next element only when `reqValid` and `reqReady` are both high. Otherwise the element number is held.
- R7: `reqElem` counts 0 to VL−1 over the run. `reqLast` is high exactly on element VL−1.
- R8: `done` is high for exactly one cycle, the cycle after the last request is accepted, and `busy` is low in that cycle.
- R9: A start with `vecLen` = 0 issues no request and raises `done` in the cycle after the start.
- R10: A `vecLen` above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence when idle |
| baseAddr | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Signed byte stride for strided mode |
| addrMode | input | 2 | 0 unit stride, 1 strided, 2 or 3 indexed |
| elemWidth | input | 2 | Element size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| vecLen | input | VL_W | Number of elements, 0 to MAX_VL |
| idxValid | input | 1 | Index offset is valid |
| idxOffset | input | ADDR_W | Byte offset of the current indexed element |
| idxReady | output | 1 | Index offset is taken when valid |
| reqValid | output | 1 | Element request valid |
| reqReady | input | 1 | Memory accepts the request |
| reqAddr | output | ADDR_W | Element byte address |
| reqElem | output | ELEM_W | Element number |
| reqLast | output | 1 | Request is for the final element |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle: acceptance of the final element and a fresh `start`. The bench forces this collision by holding `reqReady` high on a three-element run and raising `start`, carrying a one-element run, exactly as the last request is taken. That start must be dropped. A second start is then given in the cycle where `done` is high, and it must be taken. Any stray or missing request shows as a scoreboard mismatch on address, element number or last flag.

// File: rtl/vaseq_pkg.sv
package vaseq_pkg;

  typedef enum logic [1:0] {
    AM_UNIT     = 2'd0,
    AM_STRIDE   = 2'd1,
    AM_INDEX    = 2'd2,
    AM_INDEX_B  = 2'd3
  } addrMode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

endpackage

// File: rtl/vaseq_datapath.sv
module vaseq_datapath
  import vaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int ELEM_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [1:0]        addrMode,
  input  logic [1:0]        elemWidth,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [ADDR_W-1:0] idxOffset,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ELEM_W-1:0] elemOut,
  output logic              lastOut,
  output logic              lenZero,
  output logic              indexed
);

  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic [ADDR_W-1:0] baseQ, strideQ, accQ, stepSize;
  addrMode_e         modeQ;
  logic [1:0]        widthQ;
  logic [VL_W-1:0]   vlQ, vlClamped;
  logic [ELEM_W-1:0] elemQ;

  assign vlClamped = (vecLen > VL_CAP) ? VL_CAP : vecLen;
  assign lenZero   = (vecLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      strideQ <= '0;
      modeQ   <= AM_UNIT;
      widthQ  <= '0;
      vlQ     <= '0;
      elemQ   <= '0;
      accQ    <= '0;
    end else if (strb.load) begin
      baseQ   <= baseAddr;
      strideQ <= stride;
      modeQ   <= addrMode_e'(addrMode);
      widthQ  <= elemWidth;
      vlQ     <= vlClamped;
      elemQ   <= '0;
      accQ    <= baseAddr;
    end else if (strb.advance) begin
      elemQ   <= elemQ + ELEM_W'(1);
      accQ    <= accQ + stepSize;
    end
  end

  always_comb begin
    case (modeQ)
      AM_STRIDE: stepSize = strideQ;
      default:   stepSize = ADDR_W'(1) << widthQ;
    endcase
  end

  assign indexed = modeQ[1];
  assign addrOut = indexed ? (baseQ + idxOffset) : accQ;
  assign elemOut = elemQ;
  assign lastOut = ((VL_W'(elemQ) + VL_W'(1)) == vlQ);

endmodule

// File: rtl/vaseq_ctrl.sv
module vaseq_ctrl
  import vaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lenZero,
  input  logic       indexed,
  input  logic       lastIn,
  input  logic       idxValid,
  input  logic       reqReady,
  output seqStrobe_t strb,
  output logic       reqValid,
  output logic       idxReady,
  output logic       busy,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  seqState_e stateQ, stateD;
  logic      accept, doneD;

  assign busy     = (stateQ == ST_RUN);
  assign reqValid = busy && (!indexed || idxValid);
  assign idxReady = busy && indexed && reqReady;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strb.load    = (stateQ == ST_IDLE) && start;
    strb.advance = accept;
  end

  always_comb begin
    stateD = stateQ;
    doneD  = 1'b0;
    case (stateQ)
      ST_IDLE: if (start) begin
        if (lenZero) doneD = 1'b1;
        else         stateD = ST_RUN;
      end
      ST_RUN: if (accept && lastIn) begin
        stateD = ST_IDLE;
        doneD  = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= doneD;
    end
  end

endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq
  import vaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 64,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int ELEM_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [1:0]        addrMode,
  input  logic [1:0]        elemWidth,
  input  logic [VL_W-1:0]   vecLen,
  input  logic              idxValid,
  input  logic [ADDR_W-1:0] idxOffset,
  output logic              idxReady,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ELEM_W-1:0] reqElem,
  output logic              reqLast,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strb;
  logic       lenZero, indexed, lastFlag;

  vaseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lenZero  (lenZero),
    .indexed  (indexed),
    .lastIn   (lastFlag),
    .idxValid (idxValid),
    .reqReady (reqReady),
    .strb     (strb),
    .reqValid (reqValid),
    .idxReady (idxReady),
    .busy     (busy),
    .done     (done)
  );

  vaseq_datapath #(
    .ADDR_W (ADDR_W),
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W),
    .ELEM_W (ELEM_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .stride    (stride),
    .addrMode  (addrMode),
    .elemWidth (elemWidth),
    .vecLen    (vecLen),
    .idxOffset (idxOffset),
    .addrOut   (reqAddr),
    .elemOut   (reqElem),
    .lastOut   (lastFlag),
    .lenZero   (lenZero),
    .indexed   (indexed)
  );

  assign reqLast = lastFlag;

endmodule

// File: rtl/vaseq_checker.sv
module vaseq_checker #(
  parameter int VL_W   = 7,
  parameter int ELEM_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [VL_W-1:0]   vecLen,
  input logic              idxValid,
  input logic              idxReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ELEM_W-1:0] reqElem,
  input logic              reqLast,
  input logic              busy,
  input logic              done
);

  a_r1_idle_no_request: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

  a_r5_index_ready_only_running: assert property (@(posedge clk) disable iff (!rstN)
    idxReady |-> (busy && reqReady));

  a_r5_index_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (idxReady && !idxValid) |-> !reqValid);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (busy && $stable(reqElem)));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqLast) |=> (busy && reqElem == $past(reqElem) + ELEM_W'(1)));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLast) |=> (done && !busy));

  a_r8_done_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_zero_length: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && vecLen == '0) |=> (done && !busy));

endmodule

bind vec_addr_seq vaseq_checker #(.VL_W(VL_W), .ELEM_W(ELEM_W)) u_vaseq_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .vecLen   (vecLen),
  .idxValid (idxValid),
  .idxReady (idxReady),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqElem  (reqElem),
  .reqLast  (reqLast),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_vec_addr_seq.sv
module test_vec_addr_seq;

  localparam int AW   = 32;
  localparam int MAXV = 64;
  localparam int VLW  = $clog2(MAXV + 1);
  localparam int EW   = $clog2(MAXV);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, start, idxValid, idxReady, reqValid, reqReady, reqLast, busy, done;
  logic [AW-1:0] baseAddr, stride, idxOffset, reqAddr;
  logic [1:0]    addrMode, elemWidth;
  logic [VLW-1:0] vecLen;
  logic [EW-1:0] reqElem;

  vec_addr_seq #(.ADDR_W(AW), .MAX_VL(MAXV)) i_vec_addr_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .stride(stride),
    .addrMode(addrMode), .elemWidth(elemWidth), .vecLen(vecLen),
    .idxValid(idxValid), .idxOffset(idxOffset), .idxReady(idxReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqElem(reqElem), .reqLast(reqLast), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int reqCnt = 0;
  string tagNow = "R3";

  logic [AW-1:0] qAddr[$];
  int            qElem[$];
  bit            qLast[$];

  logic [AW-1:0] idxMem [MAXV];
  int  idxCnt = 0;
  int  idxPtr = 0;
  bit  readyAll = 1'b1;
  bit  idxAll = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [AW-1:0] ea;
    int ee;
    bit el;
    if (rstN && reqValid && reqReady) begin
      reqCnt++;
      if (qAddr.size() == 0) begin
        chk(1'b0, "R2", "request with none expected", reqAddr, 0);
      end else begin
        ea = qAddr.pop_front();
        ee = qElem.pop_front();
        el = qLast.pop_front();
        chk(reqAddr == ea, tagNow, "address", reqAddr, ea);
        chk(int'(reqElem) == ee, "R7", "element number", reqElem, ee);
        chk(reqLast == el, "R7", "last flag", reqLast, el);
      end
    end
  end

  // memory ready driver
  initial begin
    reqReady = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqReady = readyAll ? 1'b1 : (lfsr[0] | lfsr[3]);
    end
  end

  // index stream driver
  initial begin
    bit take;
    idxValid = 1'b0;
    idxOffset = '0;
    forever begin
      @(negedge clk);
      take = idxReady && idxValid;
      @(posedge clk); #1;
      if (take) idxPtr++;
      idxValid  = (idxPtr < idxCnt) && (idxAll || lfsr[5]);
      idxOffset = idxMem[(idxPtr < MAXV) ? idxPtr : 0];
    end
  end

  task automatic pushExp(input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int m, input int w, input int vl);
    int n;
    logic [AW-1:0] a;
    n = (vl > MAXV) ? MAXV : vl;
    for (int i = 0; i < n; i++) begin
      if (m == 0)      a = b + AW'(i) * (AW'(1) << w);
      else if (m == 1) a = b + AW'(i) * s;
      else             a = b + idxMem[i];
      qAddr.push_back(a);
      qElem.push_back(i);
      qLast.push_back(i == n - 1);
    end
  endtask

  task automatic setIn(input logic [AW-1:0] b, input logic [AW-1:0] s,
                       input int m, input int w, input int vl);
    baseAddr  = b;
    stride    = s;
    addrMode  = 2'(m);
    elemWidth = 2'(w);
    vecLen    = VLW'(vl);
  endtask

  task automatic waitDone(input string tag, input int expN, input int r0);
    int t;
    t = 0;
    forever begin
      @(negedge clk);
      t++;
      if (done || t > 5000) break;
    end
    chk(done, "R8", {tag, " done raised"}, done, 1);
    chk(!busy, "R8", "busy low with done", busy, 0);
    chk(qAddr.size() == 0, tag, "all expected requests seen", qAddr.size(), 0);
    chk(reqCnt - r0 == expN, tag, "request count", reqCnt - r0, expN);
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", done, 0);
  endtask

  task automatic runSeq(input string tag, input logic [AW-1:0] b, input logic [AW-1:0] s,
                        input int m, input int w, input int vl);
    int r0;
    tagNow = tag;
    pushExp(b, s, m, w, vl);
    r0 = reqCnt;
    @(posedge clk); #1;
    setIn(b, s, m, w, vl);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    setIn(32'hDEAD_BEEF, 32'h1234_5678, (m + 1) % 4, (w + 1) % 4, 3); // R2: later input changes ignored
    waitDone(tag, (vl > MAXV) ? MAXV : vl, r0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    int r0;
    rstN = 1'b0;
    start = 1'b0;
    setIn('0, '0, 0, 0, 0);
    for (int i = 0; i < MAXV; i++) idxMem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!reqValid, "R1", "reqValid in reset", reqValid, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!done, "R1", "done in reset", done, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqValid && !busy && !done, "R1", "quiet after reset", {reqValid, busy, done}, 0);

    // R3 unit stride, every width, free-running and stalled memory
    runSeq("R3", 32'h0000_1000, '0, 0, 2, 5);
    readyAll = 1'b0;
    for (int w = 0; w < 4; w++) runSeq("R3", 32'h0004_0000 + w * 32'h100, '0, 0, w, 9 + w);
    runSeq("R3", 32'hFFFF_FFF0, '0, 0, 3, MAXV);

    // R4 strided, positive and negative with wrap
    runSeq("R4", 32'h0000_2000, 32'd24, 1, 0, 11);
    runSeq("R4", 32'h0000_0020, 32'hFFFF_FFF4, 1, 2, 7);

    // R5 indexed with gaps in the index stream
    idxAll = 1'b0;
    for (int i = 0; i < MAXV; i++) idxMem[i] = AW'((i * 37 + 5) % 211) * 8 - 32'd64;
    idxCnt = 6; idxPtr = 0;
    @(posedge clk);
    runSeq("R5", 32'h0010_0000, '0, 2, 1, 6);
    idxCnt = 1; idxPtr = 0;
    @(posedge clk);
    runSeq("R5", 32'h0020_0000, '0, 3, 0, 1);
    idxAll = 1'b1;
    idxCnt = 0; idxPtr = 0;

    // R10 oversized length clamps to MAXV
    runSeq("R10", 32'h0003_0000, '0, 0, 0, MAXV + 6);

    // R9 zero length
    r0 = reqCnt;
    @(posedge clk); #1;
    setIn(32'h5000, '0, 0, 0, 0);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(done, "R9", "done one cycle after zero-length start", done, 1);
    chk(!busy, "R9", "not busy on zero length", busy, 0);
    repeat (4) @(negedge clk);
    chk(reqCnt == r0, "R9", "no requests for zero length", reqCnt - r0, 0);

    // R2 start while busy is ignored
    fork
      runSeq("R3", 32'h0007_0000, '0, 0, 1, 10);
      begin
        repeat (4) @(posedge clk);
        #2;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    chk(!busy, "R2", "no run from ignored start", busy, 0);

    // R2 collision: start with last accept is dropped, start with done is taken
    readyAll = 1'b1;
    tagNow = "R2";
    pushExp(32'h0008_0000, '0, 0, 2, 3);
    r0 = reqCnt;
    @(posedge clk); #1;
    setIn(32'h0008_0000, '0, 0, 2, 3);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    setIn(32'h0BAD_0000, '0, 0, 0, 1);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(done, "R8", "done after last of collision run", done, 1);
    chk(reqCnt - r0 == 3, "R2", "collision run request count", reqCnt - r0, 3);
    pushExp(32'h0009_0000, '0, 0, 0, 2);
    r0 = reqCnt;
    setIn(32'h0009_0000, '0, 0, 0, 2);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    waitDone("R2", 2, r0);

    repeat (3) @(negedge clk);
    chk(qAddr.size() == 0, "R2", "scoreboard drained", qAddr.size(), 0);
    summary();
    $finish;
  end

endmodule